// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-style memory interface. It watches the bus write strobe, captures the address and data of every write cycle on the strobe's falling edge, and follows the multi-cycle unlock and command sequences. When a sequence completes it emits a single-cycle operation pulse and updates the latched bank and sector addresses. The storage array, program and erase timing, and the protection hardware are not part of it. The block only classifies write sequences and reports its mode.

The decoder supports word and byte addressing. In byte mode the address bus carries one extra low bit, so the unlock addresses change form. The decoder also tracks a hidden one-time-programmable region. Erasing that region and leaving it are accepted only while the hidden mode is on. The hidden region sits in the top bank or the bottom bank, selected by a parameter. While the protection-verify mode is active, a small read-data output reports whether the sector flagged by the protection hardware is protected.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset all four operation pulses are low, `hidden_mode` and `verify_mode` are 0, and `sector_addr`, `bank_addr` and `vfy_data` are 0.
- R2: A write cycle is taken once, at the clock where `wr_n` is first sampled low after being sampled high. A strobe held low over several clocks counts as one cycle. A pulse caused by that cycle is high during the cycle two clocks after that first low sample, and for exactly one cycle.
- R3: The first unlock address matches when the low bits equal 555h (A10..A0, word mode) or AAAh (A10..A-1, byte mode). The second unlock address matches 2AAh (word mode) or 555h (byte mode). In word mode `addr[20:0]` is A20..A0 and `addr[21]` is unused. In byte mode `addr[21:0]` is A20..A-1.
- R4: Read/reset has two forms with the same effect: a single write of F0h to any address when no sequence is open, or F0h written as the third cycle after the unlock pair. Either form pulses `op_reset` and clears `verify_mode`.
- R5: With hidden mode off, the unlock pair followed by 90h at the first unlock address pulses `op_prot_vfy`, sets `verify_mode` and latches the bank and sector of that address. While `verify_mode` is 1, `vfy_data` is 01h when `sect_prot` is 1 and 00h when it is 0. Otherwise `vfy_data` is 00h. `verify_mode` is cleared by the next reset, aborted sequence, hidden entry, hidden erase or hidden exit.
- R6: The unlock pair followed by 88h at the first unlock address sets `hidden_mode`. No operation pulse is produced.
- R7: With hidden mode on, AAh, 55h, 80h, AAh, 55h (each at its unlock address), then 30h at a hidden-region address pulses `op_hr_erase`. The address of the sixth cycle is latched into `sector_addr` (A20..A12) and `bank_addr` (A20..A15). An address is in the hidden region when A20..A15 are all 1 with `TOP_BOOT`=1, or all 0 with `TOP_BOOT`=0. If the sixth cycle's address is outside the region, the sequence aborts.
- R8: With hidden mode on, the unlock pair, then 90h at the first unlock address inside the hidden-region bank, then 00h at any address pulses `op_hr_exit`. `hidden_mode` goes to 0 in the same cycle as the pulse.
- R9: With hidden mode off, 80h after the unlock pair aborts the sequence, so no erase can follow. 90h after the unlock pair starts protection verify, not hidden exit.
- R10: Any write that does not continue the open sequence aborts it. The decoder produces no pulse, clears `verify_mode`, keeps `hidden_mode`, and the next write is treated as the first cycle of a new sequence.
- R11: Address bits A20..A11 have no effect on whether a cycle matches an unlock or command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects byte addressing (extra low address bit) |
| wr_n | input | 1 | Bus write strobe, active low |
| addr | input | 22 | Bus address; layout depends on `byte_mode` |
| data | input | 8 | Bus write data |
| sect_prot | input | 1 | Protection state of the addressed sector from protection hardware |
| op_reset | output | 1 | Read/reset command pulse |
| op_hr_erase | output | 1 | Hidden-region erase command pulse |
| op_hr_exit | output | 1 | Hidden-region exit command pulse |
| op_prot_vfy | output | 1 | Protection-verify entry pulse |
| sector_addr | output | 9 | Latched sector address A20..A12 |
| bank_addr | output | 6 | Latched bank address A20..A15 |
| hidden_mode | output | 1 | Hidden region mode active |
| verify_mode | output | 1 | Protection-verify mode active |
| vfy_data | output | 8 | Verify read data, 01h protected / 00h unprotected |

## Verification
Two events can fall in the same clock cycle. One is the completion pulse of one sequence. The other is the capture of the next write's falling edge, which happens when strobes come every other clock. Also, the hidden-exit pulse must coincide with `hidden_mode` dropping. The bench drives writes at the minimum two-clock spacing, both directed and in long random streams of intact and corrupted sequences. It counts every pulse at the falling clock edge and compares the counts, the modes and the latched addresses against a model written from the requirements. A lost or doubled pulse, or a mode change one cycle early or late, shows up as a count or mode mismatch.

// File: rtl/nfd_pkg.sv
package nfd_pkg;

    localparam int ADDR_W  = 22;
    localparam int DATA_W  = 8;
    localparam int WADDR_W = ADDR_W - 1;
    localparam int BANK_W  = 6;
    localparam int SECT_W  = 9;
    localparam int UL_W    = 11;

    localparam logic [DATA_W-1:0] CMD_UL_A   = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_UL_B   = 8'h55;
    localparam logic [DATA_W-1:0] CMD_RESET  = 8'hF0;
    localparam logic [DATA_W-1:0] CMD_SETUP  = 8'h80;
    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h30;
    localparam logic [DATA_W-1:0] CMD_QUERY  = 8'h90;
    localparam logic [DATA_W-1:0] CMD_ENTER  = 8'h88;
    localparam logic [DATA_W-1:0] CMD_LEAVE  = 8'h00;

    localparam logic [UL_W-1:0] UL_WORD_A = 11'h555;
    localparam logic [UL_W-1:0] UL_WORD_B = 11'h2AA;
    localparam logic [UL_W:0]   UL_BYTE_A = 12'hAAA;
    localparam logic [UL_W:0]   UL_BYTE_B = 12'h555;

    typedef struct packed {
        logic              valid;
        logic              byte_mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_cycle_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UL1,
        ST_UL2,
        ST_ER_CMD,
        ST_ER_UL1,
        ST_ER_UL2,
        ST_EXIT_CMD
    } seq_state_e;

    typedef struct packed {
        logic do_reset;
        logic do_erase;
        logic do_exit;
        logic do_vfy;
        logic do_enter;
        logic do_abort;
        logic do_latch;
    } seq_event_t;

    function automatic logic [WADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] a,
                                                     input logic bm);
        return bm ? a[ADDR_W-1:1] : a[WADDR_W-1:0];
    endfunction

    function automatic logic unlock_match(input logic [ADDR_W-1:0] a,
                                          input logic bm,
                                          input logic second);
        logic hit;
        if (bm)
            hit = (a[UL_W:0] == (second ? UL_BYTE_B : UL_BYTE_A));
        else
            hit = (a[UL_W-1:0] == (second ? UL_WORD_B : UL_WORD_A));
        return hit;
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [WADDR_W-1:0] w);
        return w[WADDR_W-1 -: BANK_W];
    endfunction

    function automatic logic [SECT_W-1:0] sector_of(input logic [WADDR_W-1:0] w);
        return w[WADDR_W-1 -: SECT_W];
    endfunction

endpackage

// File: rtl/nfd_strobe_capture.sv
module nfd_strobe_capture
    import nfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_cycle_t         cyc
);
    logic wr_n_q;
    logic fall;

    assign fall = wr_n_q & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            cyc    <= '0;
        end else begin
            wr_n_q    <= wr_n;
            cyc.valid <= fall;
            if (fall) begin
                cyc.byte_mode <= byte_mode;
                cyc.addr      <= addr;
                cyc.data      <= data;
            end
        end
    end
endmodule

// File: rtl/nfd_addr_classify.sv
module nfd_addr_classify
    import nfd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  wr_cycle_t          cyc,
    output logic               is_ul1,
    output logic               is_ul2,
    output logic               hr_hit,
    output logic [BANK_W-1:0]  bank,
    output logic [SECT_W-1:0]  sector
);
    localparam logic [BANK_W-1:0] HR_BANK = {BANK_W{TOP_BOOT}};

    logic [WADDR_W-1:0] wa;

    always_comb begin
        wa     = word_addr(cyc.addr, cyc.byte_mode);
        is_ul1 = unlock_match(cyc.addr, cyc.byte_mode, 1'b0);
        is_ul2 = unlock_match(cyc.addr, cyc.byte_mode, 1'b1);
        bank   = bank_of(wa);
        sector = sector_of(wa);
        hr_hit = (bank == HR_BANK);
    end
endmodule

// File: rtl/nfd_seq_fsm.sv
module nfd_seq_fsm
    import nfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              is_ul1,
    input  logic              is_ul2,
    input  logic              hr_hit,
    input  logic              hidden_mode,
    output seq_event_t        ev
);
    seq_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        ev     = '0;
        if (cyc_valid) begin
            unique case (st)
                ST_IDLE: begin
                    if (cyc_data == CMD_RESET)
                        ev.do_reset = 1'b1;
                    else if (cyc_data == CMD_UL_A && is_ul1)
                        st_nxt = ST_UL1;
                    else
                        ev.do_abort = 1'b1;
                end
                ST_UL1: begin
                    if (cyc_data == CMD_UL_B && is_ul2)
                        st_nxt = ST_UL2;
                    else begin
                        st_nxt      = ST_IDLE;
                        ev.do_abort = 1'b1;
                    end
                end
                ST_UL2: begin
                    st_nxt = ST_IDLE;
                    if (cyc_data == CMD_RESET)
                        ev.do_reset = 1'b1;
                    else if (cyc_data == CMD_ENTER && is_ul1)
                        ev.do_enter = 1'b1;
                    else if (cyc_data == CMD_QUERY && is_ul1) begin
                        if (!hidden_mode) begin
                            ev.do_vfy   = 1'b1;
                            ev.do_latch = 1'b1;
                        end else if (hr_hit) begin
                            ev.do_latch = 1'b1;
                            st_nxt      = ST_EXIT_CMD;
                        end else
                            ev.do_abort = 1'b1;
                    end else if (cyc_data == CMD_SETUP && is_ul1 && hidden_mode)
                        st_nxt = ST_ER_CMD;
                    else
                        ev.do_abort = 1'b1;
                end
                ST_ER_CMD: begin
                    if (cyc_data == CMD_UL_A && is_ul1)
                        st_nxt = ST_ER_UL1;
                    else begin
                        st_nxt      = ST_IDLE;
                        ev.do_abort = 1'b1;
                    end
                end
                ST_ER_UL1: begin
                    if (cyc_data == CMD_UL_B && is_ul2)
                        st_nxt = ST_ER_UL2;
                    else begin
                        st_nxt      = ST_IDLE;
                        ev.do_abort = 1'b1;
                    end
                end
                ST_ER_UL2: begin
                    st_nxt = ST_IDLE;
                    if (cyc_data == CMD_ERASE && hr_hit && hidden_mode) begin
                        ev.do_erase = 1'b1;
                        ev.do_latch = 1'b1;
                    end else
                        ev.do_abort = 1'b1;
                end
                ST_EXIT_CMD: begin
                    st_nxt = ST_IDLE;
                    if (cyc_data == CMD_LEAVE && hidden_mode)
                        ev.do_exit = 1'b1;
                    else
                        ev.do_abort = 1'b1;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/nfd_status_regs.sv
module nfd_status_regs
    import nfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_event_t        ev,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [SECT_W-1:0] sector_in,
    input  logic              sect_prot,
    output logic              op_reset,
    output logic              op_hr_erase,
    output logic              op_hr_exit,
    output logic              op_prot_vfy,
    output logic [SECT_W-1:0] sector_addr,
    output logic [BANK_W-1:0] bank_addr,
    output logic              hidden_mode,
    output logic              verify_mode,
    output logic [DATA_W-1:0] vfy_data
);
    logic ends_verify;

    assign ends_verify = ev.do_reset | ev.do_abort | ev.do_enter
                       | ev.do_erase | ev.do_exit;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_reset    <= 1'b0;
            op_hr_erase <= 1'b0;
            op_hr_exit  <= 1'b0;
            op_prot_vfy <= 1'b0;
            sector_addr <= '0;
            bank_addr   <= '0;
            hidden_mode <= 1'b0;
            verify_mode <= 1'b0;
        end else begin
            op_reset    <= ev.do_reset;
            op_hr_erase <= ev.do_erase;
            op_hr_exit  <= ev.do_exit;
            op_prot_vfy <= ev.do_vfy;
            if (ev.do_latch) begin
                sector_addr <= sector_in;
                bank_addr   <= bank_in;
            end
            if (ev.do_enter)
                hidden_mode <= 1'b1;
            else if (ev.do_exit)
                hidden_mode <= 1'b0;
            if (ev.do_vfy)
                verify_mode <= 1'b1;
            else if (ends_verify)
                verify_mode <= 1'b0;
        end
    end

    assign vfy_data = verify_mode ? {{(DATA_W-1){1'b0}}, sect_prot} : '0;
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nfd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              sect_prot,
    output logic              op_reset,
    output logic              op_hr_erase,
    output logic              op_hr_exit,
    output logic              op_prot_vfy,
    output logic [SECT_W-1:0] sector_addr,
    output logic [BANK_W-1:0] bank_addr,
    output logic              hidden_mode,
    output logic              verify_mode,
    output logic [DATA_W-1:0] vfy_data
);
    wr_cycle_t         cyc;
    logic              is_ul1, is_ul2, hr_hit;
    logic [BANK_W-1:0] cyc_bank;
    logic [SECT_W-1:0] cyc_sector;
    seq_event_t        ev;

    nfd_strobe_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .wr_n      (wr_n),
        .byte_mode (byte_mode),
        .addr      (addr),
        .data      (data),
        .cyc       (cyc)
    );

    nfd_addr_classify #(.TOP_BOOT(TOP_BOOT)) u_cls (
        .cyc    (cyc),
        .is_ul1 (is_ul1),
        .is_ul2 (is_ul2),
        .hr_hit (hr_hit),
        .bank   (cyc_bank),
        .sector (cyc_sector)
    );

    nfd_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cyc_valid   (cyc.valid),
        .cyc_data    (cyc.data),
        .is_ul1      (is_ul1),
        .is_ul2      (is_ul2),
        .hr_hit      (hr_hit),
        .hidden_mode (hidden_mode),
        .ev          (ev)
    );

    nfd_status_regs u_sts (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .bank_in     (cyc_bank),
        .sector_in   (cyc_sector),
        .sect_prot   (sect_prot),
        .op_reset    (op_reset),
        .op_hr_erase (op_hr_erase),
        .op_hr_exit  (op_hr_exit),
        .op_prot_vfy (op_prot_vfy),
        .sector_addr (sector_addr),
        .bank_addr   (bank_addr),
        .hidden_mode (hidden_mode),
        .verify_mode (verify_mode),
        .vfy_data    (vfy_data)
    );
endmodule

// File: rtl/nfd_checker.sv
module nfd_checker (
    input logic       clk,
    input logic       rst,
    input logic       op_reset,
    input logic       op_hr_erase,
    input logic       op_hr_exit,
    input logic       op_prot_vfy,
    input logic       hidden_mode,
    input logic       verify_mode,
    input logic [7:0] vfy_data
);
    // R2
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_reset, op_hr_erase, op_hr_exit, op_prot_vfy}));

    // R2
    pulse_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (op_reset | op_hr_erase | op_hr_exit | op_prot_vfy)
        |=> !(op_reset | op_hr_erase | op_hr_exit | op_prot_vfy));

    // R8
    exit_drops_mode_chk: assert property (@(posedge clk) disable iff (rst)
        op_hr_exit |-> (!hidden_mode && $past(hidden_mode)));

    // R7
    erase_in_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        op_hr_erase |-> hidden_mode);

    // R5
    vfy_enters_mode_chk: assert property (@(posedge clk) disable iff (rst)
        op_prot_vfy |-> (verify_mode && !hidden_mode));

    // R4
    reset_ends_vfy_chk: assert property (@(posedge clk) disable iff (rst)
        op_reset |-> !verify_mode);

    // R5
    vfy_data_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !verify_mode |-> (vfy_data == 8'h00));

    // R6
    hidden_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hidden_mode) |-> !(op_reset | op_hr_erase | op_hr_exit | op_prot_vfy));
endmodule

bind nor_cmd_decoder nfd_checker i_nfd_checker (
    .clk         (clk),
    .rst         (rst),
    .op_reset    (op_reset),
    .op_hr_erase (op_hr_erase),
    .op_hr_exit  (op_hr_exit),
    .op_prot_vfy (op_prot_vfy),
    .hidden_mode (hidden_mode),
    .verify_mode (verify_mode),
    .vfy_data    (vfy_data)
);

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
    localparam bit TB_TOP = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_mode = 1'b0;
    logic        wr_n = 1'b1;
    logic [21:0] addr = '0;
    logic [7:0]  data = '0;
    logic        sect_prot = 1'b0;
    logic        op_reset, op_hr_erase, op_hr_exit, op_prot_vfy;
    logic [8:0]  sector_addr;
    logic [5:0]  bank_addr;
    logic        hidden_mode, verify_mode;
    logic [7:0]  vfy_data;

    always #2.5 clk = ~clk;

    nor_cmd_decoder #(.TOP_BOOT(TB_TOP)) i_nor_cmd_decoder (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_n(wr_n), .addr(addr),
        .data(data), .sect_prot(sect_prot), .op_reset(op_reset),
        .op_hr_erase(op_hr_erase), .op_hr_exit(op_hr_exit), .op_prot_vfy(op_prot_vfy),
        .sector_addr(sector_addr), .bank_addr(bank_addr), .hidden_mode(hidden_mode),
        .verify_mode(verify_mode), .vfy_data(vfy_data)
    );

    int n_cmp = 0, n_bad = 0;
    int c_rst = 0, c_ers = 0, c_ext = 0, c_vfy = 0;
    always @(negedge clk) begin
        if (!rst) begin
            c_rst += int'(op_reset);
            c_ers += int'(op_hr_erase);
            c_ext += int'(op_hr_exit);
            c_vfy += int'(op_prot_vfy);
        end
    end

    // reference model state
    int       ms = 0;
    bit       m_hid = 0, m_vfy = 0;
    int       e_rst = 0, e_ers = 0, e_ext = 0, e_vfy = 0;
    bit [8:0] e_sec = '0;
    bit [5:0] e_bank = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(logic [20:0] w, bit bm, bit lsb);
        return bm ? {w, lsb} : {1'b0, w};
    endfunction

    function automatic logic [21:0] ul(bit second, bit bm, logic [9:0] hi);
        return second ? mk({hi, 11'h2AA}, bm, 1'b1) : mk({hi, 11'h555}, bm, 1'b0);
    endfunction

    function automatic logic [21:0] hra(bit bm, logic [14:0] lo, bit lsb);
        return mk({{6{TB_TOP}}, lo}, bm, lsb);
    endfunction

    task automatic mdl(logic [21:0] a, logic [7:0] d, bit bm);
        logic [20:0] w;
        bit u1, u2, hr, term, vf, lat;
        w  = bm ? a[21:1] : a[20:0];
        u1 = bm ? (a[11:0] == 12'hAAA) : (a[10:0] == 11'h555);
        u2 = bm ? (a[11:0] == 12'h555) : (a[10:0] == 11'h2AA);
        hr = (w[20:15] == {6{TB_TOP}});
        term = 0; vf = 0; lat = 0;
        case (ms)
            0: if (d == 8'hF0) begin e_rst++; term = 1; end
               else if (d == 8'hAA && u1) ms = 1;
               else term = 1;
            1: if (d == 8'h55 && u2) ms = 2; else begin ms = 0; term = 1; end
            2: begin
                ms = 0;
                if (d == 8'hF0) begin e_rst++; term = 1; end
                else if (d == 8'h88 && u1) begin m_hid = 1; term = 1; end
                else if (d == 8'h90 && u1) begin
                    if (!m_hid) begin e_vfy++; vf = 1; lat = 1; end
                    else if (hr) begin lat = 1; ms = 6; end
                    else term = 1;
                end
                else if (d == 8'h80 && u1 && m_hid) ms = 3;
                else term = 1;
            end
            3: if (d == 8'hAA && u1) ms = 4; else begin ms = 0; term = 1; end
            4: if (d == 8'h55 && u2) ms = 5; else begin ms = 0; term = 1; end
            5: begin
                ms = 0; term = 1;
                if (d == 8'h30 && hr) begin e_ers++; lat = 1; end
            end
            default: begin
                ms = 0; term = 1;
                if (d == 8'h00) begin e_ext++; m_hid = 0; end
            end
        endcase
        if (lat) begin e_sec = w[20:12]; e_bank = w[20:15]; end
        if (vf) m_vfy = 1; else if (term) m_vfy = 0;
    endtask

    task automatic wr(logic [21:0] a, logic [7:0] d, bit bm);
        @(negedge clk);
        byte_mode = bm; addr = a; data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        mdl(a, d, bm);
    endtask

    task automatic compare(string req);
        repeat (3) @(negedge clk);
        check(req, c_rst, e_rst);
        check(req, c_ers, e_ers);
        check(req, c_ext, e_ext);
        check(req, c_vfy, e_vfy);
        check(req, hidden_mode, m_hid);
        check(req, verify_mode, m_vfy);
        check(req, sector_addr, e_sec);
        check(req, bank_addr, e_bank);
        check(req, vfy_data, (m_vfy && sect_prot) ? 8'h01 : 8'h00);
    endtask

    task automatic unlock(bit bm, logic [9:0] hi);
        wr(ul(0, bm, hi), 8'hAA, bm);
        wr(ul(1, bm, ~hi), 8'h55, bm);
    endtask

    task automatic random_seq(int kind, bit bm, bit corrupt);
        logic [7:0] flip;
        int         pos, idx;
        logic [21:0] av[6];
        logic [7:0]  dv[6];
        int          n;
        logic [9:0]  hi;
        hi = 10'($urandom);
        av[0] = ul(0, bm, hi); dv[0] = 8'hAA;
        av[1] = ul(1, bm, hi); dv[1] = 8'h55;
        av[2] = ul(0, bm, ~hi);
        n = 3;
        case (kind)
            0: begin n = 1; av[0] = 22'($urandom); dv[0] = 8'hF0; end
            1: dv[2] = 8'hF0;
            2: dv[2] = 8'h88;
            3: dv[2] = 8'h90;
            4: begin
                dv[2] = 8'h80; av[3] = ul(0, bm, hi); dv[3] = 8'hAA;
                av[4] = ul(1, bm, hi); dv[4] = 8'h55; dv[5] = 8'h30;
                av[5] = ($urandom % 2) ? hra(bm, 15'($urandom), 1'($urandom))
                                       : 22'($urandom);
                n = 6;
            end
            5: begin
                av[2] = ($urandom % 4 != 0) ? mk({{6{TB_TOP}}, 4'($urandom), 11'h555}, bm, 1'b0)
                                            : av[2];
                dv[2] = 8'h90; av[3] = 22'($urandom); dv[3] = 8'h00; n = 4;
            end
            default: begin n = 1; av[0] = 22'($urandom); dv[0] = 8'($urandom); end
        endcase
        if (corrupt) begin
            pos  = $urandom % n;
            flip = 8'($urandom % 255 + 1);
            dv[pos] = dv[pos] ^ flip;
        end
        for (idx = 0; idx < n; idx++) wr(av[idx], dv[idx], bm);
    endtask

    task automatic run();
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {op_reset, op_hr_erase, op_hr_exit, op_prot_vfy}, 0);
        check("R1", {hidden_mode, verify_mode}, 0);
        check("R1", {sector_addr, bank_addr, vfy_data}, 0);

        // R2 pulse timing with held strobe
        @(negedge clk);
        addr = 22'h12345; data = 8'hF0; wr_n = 1'b0;
        @(negedge clk);
        check("R2 early", op_reset, 0);
        @(negedge clk);
        check("R2 pulse", op_reset, 1);
        @(negedge clk);
        check("R2 single", op_reset, 0);
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        mdl(22'h12345, 8'hF0, 1'b0);
        compare("R2 held strobe");

        // R4 three-cycle reset; R5 verify word mode
        unlock(0, 10'h3FF); wr(ul(0, 0, 10'h000), 8'h90, 0);
        sect_prot = 1'b1; compare("R5 verify protected");
        sect_prot = 1'b0; compare("R5 verify unprotected");
        unlock(0, 10'h155); wr(ul(0, 0, 10'h2AA), 8'hF0, 0);
        compare("R4 three-cycle reset");

        // R3 byte mode unlock; word-form address in byte mode aborts
        unlock(1, 10'h0F0); wr(ul(0, 1, 10'h3C3), 8'h90, 1);
        sect_prot = 1'b1; compare("R3 byte-mode verify");
        wr(22'h000555, 8'hAA, 1); wr(ul(1, 1, 0), 8'h55, 1);
        compare("R3 word address in byte mode");

        // R9 erase without hidden mode
        unlock(0, 0); wr(ul(0, 0, 0), 8'h80, 0);
        unlock(0, 0); wr(hra(0, 15'h0123, 0), 8'h30, 0);
        compare("R9 erase needs hidden mode");

        // R6 entry, R7 erase, R8 exit
        unlock(0, 10'h2A5); wr(ul(0, 0, 10'h05A), 8'h88, 0);
        compare("R6 hidden entry");
        unlock(0, 0); wr(ul(0, 0, 0), 8'h80, 0); unlock(0, 0);
        wr(hra(0, 15'h5A5A, 0), 8'h30, 0);
        compare("R7 hidden erase");
        unlock(1, 0); wr(ul(0, 1, 0), 8'h80, 1); unlock(1, 0);
        wr(mk(21'h0ABCDE, 1, 0), 8'h30, 1);
        compare("R7 erase outside region");
        unlock(0, 0); wr(mk({6'h00, 4'h0, 11'h555}, 0, 0), 8'h90, 0);
        wr(22'h0, 8'h00, 0);
        compare("R8 exit wrong bank");
        unlock(0, 0); wr(mk({{6{TB_TOP}}, 4'h3, 11'h555}, 0, 0), 8'h90, 0);
        wr(22'h3FFFFF, 8'h00, 0);
        compare("R8 hidden exit");

        // R10 broken sequence, then recovery; R11 high bits ignored
        unlock(0, 0); wr(ul(0, 0, 0), 8'h90, 0);
        wr(ul(0, 0, 0), 8'hAA, 0); wr(ul(0, 0, 0), 8'h55, 0);
        compare("R10 broken unlock");
        unlock(0, 10'h3FF); wr(ul(0, 0, 10'h1F3), 8'h90, 0);
        compare("R11 high bits ignored");

        for (int i = 0; i < 300; i++) begin
            sect_prot = 1'($urandom);
            random_seq($urandom % 7, 1'($urandom), ($urandom % 5) == 0);
            if (i % 10 == 9) compare("R10 random stream");
        end
        compare("R10 random end");
    endtask

    initial begin
        bit wd = 0;
        fork
            run();
            begin repeat (150000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule